// File: doc/BRIEF.md
# Victim Writeback Exchange Buffer

This block sits in the data path between a cache and the system bus. When a miss evicts a dirty block, the cache side pushes the victim's words into a storage made of one short shift register per data bit. The replacement block then arrives from the bus through a separate receive path and is handed to the cache without touching the parked victim. Only after the fill indication drops are the victim words handed to the bus, one per shift-enable cycle. On the bus, the writeback therefore follows the fill, even though the processor asked for them the other way round.

A bypass control cuts each per-bit register down to its first stage. Ordinary block writes can then stream through with one cycle of latency and never occupy the victim storage. The bypass choice is sampled only while nothing is held, so a block is never split between the two paths.

With the default parameters each bit has four stages and the data is 128 bits wide, so one 64-byte block fits as four words.

Top module: `victim_xchg_buf`

## Requirements
- R1: After reset, `held_o` is 0 and `bus_valid_o`, `full_o` and `err_o` are all 0.
- R2: In store mode (`bypass_i` low, or any word already held), each `load_i` cycle with `held_o` below DEPTH appends `cache_data_i` as the newest word and raises `held_o` by one. `full_o` is high exactly when `held_o` equals DEPTH (4).
- R3: While words are held and `fill_active_i` is low, `bus_valid_o` is high and `bus_data_o` shows the oldest held word. A `shift_i` cycle without `load_i` removes that word, so words leave first-in first-out.
- R4: While `fill_active_i` is high, `bus_valid_o` is low for held words and `shift_i` removes nothing.
- R5: While `fill_active_i` is high, `fill_data_o` takes the value of `fill_data_i` one cycle later. The held words are unchanged by the fill.
- R6: A `load_i` while `full_o` is high is dropped. `err_o` is high for exactly the next cycle, `held_o` stays at DEPTH, and the held words are unchanged.
- R7: With nothing held and `bypass_i` high, a `load_i` word appears on `bus_data_o` with `bus_valid_o` high in the following cycle only, and `held_o` stays 0.
- R8: A high `bypass_i` while any word is held has no effect: loads still go to the store and keep their order.
- R9: When `load_i` and `shift_i` are both high in one cycle, the load is taken and the shift is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cache_data_i | input | DATA_W | Word from the cache side |
| load_i | input | 1 | Take `cache_data_i` this cycle |
| shift_i | input | 1 | Bus consumes the presented held word |
| bypass_i | input | 1 | Single-stage pass-through request |
| fill_active_i | input | 1 | Fill block is arriving from the bus |
| fill_data_i | input | DATA_W | Fill word from the bus receiver |
| fill_data_o | output | DATA_W | Registered fill word toward the cache |
| bus_data_o | output | DATA_W | Word toward the bus |
| bus_valid_o | output | 1 | `bus_data_o` carries a word |
| held_o | output | $clog2(DEPTH+1) | Number of held victim words |
| full_o | output | 1 | Store holds DEPTH words |
| err_o | output | 1 | One-cycle pulse after a dropped load |

## Verification
The sweep parks victims of every length from one to four words. Each word is a value computed from the block length and its position, so any loss, duplication or reordering shows up as a mismatch. Each parked victim then has a fill run over it with shift requested, which separates correct gating from early draining, and the later drain confirms the fill left the victim intact. Further sequences try a fifth load into a full store, bypass writes from empty, bypass raised mid-block, and load colliding with shift. These tell the overflow, mode-latching and priority rules apart from one another.

// File: rtl/vxb_pkg.sv
package vxb_pkg;
   typedef enum logic {
      VXB_STORE = 1'b0,
      VXB_PASS  = 1'b1
   } vxb_mode_e;

   // write controls for the stage array
   typedef struct packed {
      logic push_chain;  // shift every stage, new word into stage 0
      logic push_head;   // write stage 0 only (bypass)
   } vxb_wr_s;
endpackage

// File: rtl/vxb_ctrl.sv
module vxb_ctrl
   import vxb_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int CNT_W = $clog2(DEPTH + 1),
   parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             shift_i,
   input  logic             bypass_i,
   input  logic             fill_active_i,
   output vxb_wr_s          wr_o,
   output logic [IDX_W-1:0] rd_idx_o,
   output logic [CNT_W-1:0] held_o,
   output logic             full_o,
   output logic             err_o,
   output logic             pass_vld_o,
   output logic             store_vld_o
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             err_q;
   logic             pass_q;
   vxb_mode_e        mode;
   logic             empty, full, push_v, push_b, pop, reject;

   assign empty  = (cnt_q == '0);
   assign full   = (cnt_q == CNT_FULL);
   // bypass only counts when nothing is parked
   assign mode   = (empty && bypass_i) ? VXB_PASS : VXB_STORE;
   assign push_v = load_i && (mode == VXB_STORE) && !full;
   assign push_b = load_i && (mode == VXB_PASS);
   assign reject = load_i && (mode == VXB_STORE) && full;
   assign pop    = shift_i && !empty && !fill_active_i && !load_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         err_q  <= 1'b0;
         pass_q <= 1'b0;
      end else begin
         if (push_v)
            cnt_q <= cnt_q + CNT_ONE;
         else if (pop)
            cnt_q <= cnt_q - CNT_ONE;
         err_q  <= reject;
         pass_q <= push_b;
      end
   end

   assign wr_o.push_chain = push_v;
   assign wr_o.push_head  = push_b;
   assign rd_idx_o    = empty ? '0 : IDX_W'(cnt_q - CNT_ONE);
   assign held_o      = cnt_q;
   assign full_o      = full;
   assign err_o       = err_q;
   assign pass_vld_o  = pass_q;
   assign store_vld_o = !empty && !fill_active_i;
endmodule

// File: rtl/vxb_stage_array.sv
module vxb_stage_array
   import vxb_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int DEPTH  = 4,
   parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  vxb_wr_s           wr_i,
   input  logic [DATA_W-1:0] din_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] head_o,
   output logic [DATA_W-1:0] word_o
);
   logic [DEPTH-1:0][DATA_W-1:0] stg;

   for (genvar k = 0; k < DEPTH; k++) begin : g_stg
      logic [DATA_W-1:0] q;
      if (k == 0) begin : g_head
         always_ff @(posedge clk)
            if (wr_i.push_chain || wr_i.push_head)
               q <= din_i;
      end else begin : g_tail
         always_ff @(posedge clk)
            if (wr_i.push_chain)
               q <= stg[k-1];
      end
      assign stg[k] = q;
   end

   assign head_o = stg[0];
   assign word_o = stg[rd_idx_i];
endmodule

// File: rtl/vxb_fill_path.sv
module vxb_fill_path #(
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_active_i,
   input  logic [DATA_W-1:0] fill_data_i,
   output logic [DATA_W-1:0] fill_data_o
);
   logic [DATA_W-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_q <= '0;
      else if (fill_active_i)
         rx_q <= fill_data_i;
   end

   assign fill_data_o = rx_q;
endmodule

// File: rtl/victim_xchg_buf.sv
module victim_xchg_buf
   import vxb_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int DEPTH  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [DATA_W-1:0]          cache_data_i,
   input  logic                       load_i,
   input  logic                       shift_i,
   input  logic                       bypass_i,
   input  logic                       fill_active_i,
   input  logic [DATA_W-1:0]          fill_data_i,
   output logic [DATA_W-1:0]          fill_data_o,
   output logic [DATA_W-1:0]          bus_data_o,
   output logic                       bus_valid_o,
   output logic [$clog2(DEPTH+1)-1:0] held_o,
   output logic                       full_o,
   output logic                       err_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("victim_xchg_buf: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("victim_xchg_buf: DATA_W must be positive");
   end

   vxb_wr_s           wr;
   logic [IDX_W-1:0]  rd_idx;
   logic [DATA_W-1:0] head, word;
   logic              pass_vld, store_vld;

   vxb_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_i        (load_i),
      .shift_i       (shift_i),
      .bypass_i      (bypass_i),
      .fill_active_i (fill_active_i),
      .wr_o          (wr),
      .rd_idx_o      (rd_idx),
      .held_o        (held_o),
      .full_o        (full_o),
      .err_o         (err_o),
      .pass_vld_o    (pass_vld),
      .store_vld_o   (store_vld)
   );

   vxb_stage_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_stages (
      .clk      (clk),
      .wr_i     (wr),
      .din_i    (cache_data_i),
      .rd_idx_i (rd_idx),
      .head_o   (head),
      .word_o   (word)
   );

   vxb_fill_path #(.DATA_W(DATA_W)) u_fill (
      .clk           (clk),
      .rst_n         (rst_n),
      .fill_active_i (fill_active_i),
      .fill_data_i   (fill_data_i),
      .fill_data_o   (fill_data_o)
   );

   assign bus_data_o  = pass_vld ? head : ((held_o != '0) ? word : '0);
   assign bus_valid_o = pass_vld || store_vld;
endmodule

// File: rtl/vxb_checker.sv
module vxb_checker #(
   parameter int DATA_W = 128,
   parameter int DEPTH  = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       load_i,
   input logic                       shift_i,
   input logic                       bypass_i,
   input logic                       fill_active_i,
   input logic [DATA_W-1:0]          fill_data_i,
   input logic [DATA_W-1:0]          fill_data_o,
   input logic                       bus_valid_o,
   input logic [$clog2(DEPTH+1)-1:0] held_o,
   input logic                       full_o,
   input logic                       err_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   assert_held_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      held_o <= CNT_FULL);

   assert_append_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && (held_o < CNT_FULL) && ((held_o != '0) || !bypass_i)
      |=> held_o == $past(held_o) + CNT_ONE);

   assert_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i && !load_i && !fill_active_i && (held_o != '0)
      |=> held_o == $past(held_o) - CNT_ONE);

   assert_hold_in_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_active_i && !load_i |=> held_o == $past(held_o));

   assert_mute_in_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_active_i && (held_o != '0) |-> !bus_valid_o);

   assert_fill_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_active_i |=> fill_data_o == $past(fill_data_i));

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && full_o |=> err_o && (held_o == CNT_FULL));

   assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $past(load_i) && $past(full_o));

   assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && bypass_i && (held_o == '0) |=> bus_valid_o && (held_o == '0));
endmodule

bind victim_xchg_buf vxb_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_vxb_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .load_i        (load_i),
   .shift_i       (shift_i),
   .bypass_i      (bypass_i),
   .fill_active_i (fill_active_i),
   .fill_data_i   (fill_data_i),
   .fill_data_o   (fill_data_o),
   .bus_valid_o   (bus_valid_o),
   .held_o        (held_o),
   .full_o        (full_o),
   .err_o         (err_o)
);

// File: tb/victim_xchg_buf_test.sv
module victim_xchg_buf_test;
   localparam int DW = 128;
   localparam int DP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] cache_data_i = '0;
   logic          load_i = 1'b0, shift_i = 1'b0, bypass_i = 1'b0, fill_active_i = 1'b0;
   logic [DW-1:0] fill_data_i = '0;
   logic [DW-1:0] fill_data_o, bus_data_o;
   logic          bus_valid_o, full_o, err_o;
   logic [2:0]    held_o;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #4 clk = ~clk;  // 125 MHz

   victim_xchg_buf #(.DATA_W(DW), .DEPTH(DP)) uut (
      .clk(clk), .rst_n(rst_n), .cache_data_i(cache_data_i), .load_i(load_i),
      .shift_i(shift_i), .bypass_i(bypass_i), .fill_active_i(fill_active_i),
      .fill_data_i(fill_data_i), .fill_data_o(fill_data_o), .bus_data_o(bus_data_o),
      .bus_valid_o(bus_valid_o), .held_o(held_o), .full_o(full_o), .err_o(err_o));

   function automatic logic [DW-1:0] wd(int blk, int pos);
      logic [31:0] s;
      s = 32'hC0DE0000 + 32'(blk * 256 + pos * 17);
      return {s, ~s, s ^ 32'h5A5A5A5A, s + 32'd3};
   endfunction

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic put(logic [DW-1:0] d);
      load_i = 1'b1; cache_data_i = d;
      step();
      load_i = 1'b0;
      #1;
   endtask

   // drain count words of block blk expecting positions 0..cnt-1
   task automatic drain(string req, int blk, int cnt);
      for (int k = 0; k < cnt; k++) begin
         shift_i = 1'b1;
         #1;
         chk(req, DW'(bus_valid_o), DW'(1));
         chk(req, bus_data_o, wd(blk, k));
         step();
      end
      shift_i = 1'b0;
      #1;
      chk(req, DW'(held_o), DW'(0));
   endtask

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1", DW'(held_o), DW'(0));
      chk("R1", DW'(bus_valid_o), DW'(0));
      chk("R1", DW'(full_o), DW'(0));
      chk("R1", DW'(err_o), DW'(0));

      // sweep every victim length
      for (int n = 1; n <= DP; n++) begin
         for (int k = 0; k < n; k++) put(wd(n, k));
         chk("R2", DW'(held_o), DW'(n));
         chk("R2", DW'(full_o), DW'(n == DP));
         // fill runs over parked victim with shift requested
         fill_active_i = 1'b1; shift_i = 1'b1; fill_data_i = ~wd(n, 9);
         step();
         chk("R4", DW'(held_o), DW'(n));
         chk("R4", DW'(bus_valid_o), DW'(0));
         chk("R5", fill_data_o, ~wd(n, 9));
         fill_data_i = wd(n, 11);
         step();
         chk("R5", fill_data_o, wd(n, 11));
         chk("R4", DW'(held_o), DW'(n));
         fill_active_i = 1'b0; shift_i = 1'b0;
         #1;
         drain("R3", n, n);
      end

      // R6 overflow
      for (int k = 0; k < DP; k++) put(wd(7, k));
      load_i = 1'b1; cache_data_i = wd(7, 9);
      step();
      load_i = 1'b0;
      chk("R6", DW'(err_o), DW'(1));
      chk("R6", DW'(held_o), DW'(DP));
      step();
      chk("R6", DW'(err_o), DW'(0));
      drain("R6", 7, DP);

      // R7 bypass from empty
      bypass_i = 1'b1;
      put(wd(8, 0));
      chk("R7", DW'(bus_valid_o), DW'(1));
      chk("R7", bus_data_o, wd(8, 0));
      chk("R7", DW'(held_o), DW'(0));
      step();
      chk("R7", DW'(bus_valid_o), DW'(0));
      chk("R7", DW'(held_o), DW'(0));

      // R8 bypass raised while holding
      bypass_i = 1'b0;
      put(wd(9, 0));
      bypass_i = 1'b1;
      put(wd(9, 1));
      chk("R8", DW'(held_o), DW'(2));
      chk("R8", bus_data_o, wd(9, 0));
      drain("R8", 9, 2);
      bypass_i = 1'b0;

      // R9 load wins over shift
      put(wd(10, 0));
      shift_i = 1'b1;
      put(wd(10, 1));
      shift_i = 1'b0;
      #1;
      chk("R9", DW'(held_o), DW'(2));
      drain("R9", 10, 2);

      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule